// File: doc/BRIEF.md
# Rectangle Fill and Copy Engine

This block carries out the two rectangle operations of a 2D accelerator on a linear, byte-addressed framebuffer that sits behind a plain read/write memory port. A solid fill paints a rectangle with one colour. A copy moves a rectangle to another place on the same screen, and the source and destination may overlap. The pixel size (one to four bytes) and the screen width and height come from configuration inputs. Commands arrive one at a time through a valid/ready handshake, and the engine holds `busy` high while it works.

Every finished fill or copy records its destination rectangle as damage in a circular queue. A flush command drains that queue in push order. It clips each rectangle to the current screen size and presents it on a damage output. If a full redraw is already pending when the flush is accepted, the queue is thrown away and a single full-redraw pulse is produced instead. Command decoding and display scan-out belong to neighbouring blocks.

Top module: `rect_blit_engine`

## Requirements
- R1: The byte at row r and byte column b of a rectangle at (x, y) lives at address bpp*x + (bpp*screen_width)*(y+r) + b. A fill of w by h pixels issues exactly bpp*w*h byte writes.
- R2: A fill (op code 0) writes colour byte (b mod bpp) at byte column b: byte 0 is colour bits 7:0, byte 1 is bits 15:8, and so on. Every row receives the same byte pattern.
- R3: For a copy (op code 1) with destination y greater than source y, rows are processed from the bottom row upward. The result equals a copy made from a snapshot of the source.
- R4: For a copy with destination y less than or equal to source y, rows are processed from the top row downward. The result equals a copy made from a snapshot of the source.
- R5: Within a row, a copy walks bytes from the right end when destination x is greater than source x, and from the left end otherwise. A copy of a rectangle onto itself shifted along the same row is therefore exact.
- R6: Each fill or copy pushes its destination (x, y, w, h) into the damage queue. A flush (op code 2) emits the queued rectangles in push order, one per `dmg_valid` pulse, and leaves the queue empty.
- R7: The queue has DQ_DEPTH entries (512 by default), and its indices wrap modulo that depth with no full check. After exactly 512 pushes without a flush, a flush emits nothing. One further push then flushes as a single rectangle.
- R8: A flush accepted while `redraw_pend` is high discards every queued rectangle, emits no `dmg_valid`, and raises `redraw_all` for exactly one cycle. A later flush emits nothing.
- R9: At flush, a rectangle whose x+w exceeds the screen width is clipped: x becomes min(x, width) and w becomes width−x. The same rule applies to y and h against the height, using the configuration present during the flush.
- R10: `cmd_ready` is high exactly when the engine is idle. An accepted fill or copy raises `busy` the next cycle. Op code 3 is accepted and does nothing: no memory access, no damage pushed, no busy.
- R11: After reset the engine is idle and ready, with no memory enable, no damage output and no redraw pulse.
- R12: A fill or copy with w or h equal to zero touches no memory but still pushes its rectangle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_bpp | input | 3 | Bytes per pixel, 1 to 4 |
| cfg_scr_w | input | COORD_W | Screen width in pixels |
| cfg_scr_h | input | COORD_W | Screen height in pixels |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Engine idle, command taken when valid |
| cmd_op | input | 2 | 0 fill, 1 copy, 2 flush, 3 no operation |
| cmd_color | input | 32 | Fill colour, low bytes used |
| cmd_src_x | input | COORD_W | Copy source x |
| cmd_src_y | input | COORD_W | Copy source y |
| cmd_dst_x | input | COORD_W | Destination x |
| cmd_dst_y | input | COORD_W | Destination y |
| cmd_w | input | COORD_W | Rectangle width in pixels |
| cmd_h | input | COORD_W | Rectangle height in pixels |
| redraw_pend | input | 1 | Full redraw pending, sampled when a flush is accepted |
| busy | output | 1 | Operation in progress |
| mem_rd_en | output | 1 | Framebuffer byte read request |
| mem_rd_addr | output | ADDR_W | Read byte address |
| mem_rd_data | input | 8 | Read data, valid one cycle after the request is sampled |
| mem_wr_en | output | 1 | Framebuffer byte write |
| mem_wr_addr | output | ADDR_W | Write byte address |
| mem_wr_data | output | 8 | Write data |
| dmg_valid | output | 1 | Clipped damage rectangle present |
| dmg_x | output | COORD_W | Damage x |
| dmg_y | output | COORD_W | Damage y |
| dmg_w | output | COORD_W | Damage width |
| dmg_h | output | COORD_W | Damage height |
| redraw_all | output | 1 | One-cycle pulse: queue dropped, redraw whole screen |

## Verification
A fill or copy is finished in memory once `busy` has fallen: the last write enable is registered in the cycle before the engine returns to idle, and the memory model takes it on that same edge. The bench therefore compares its snapshot-based reference only after it has seen `busy` low at a falling edge, plus one spare cycle. Damage rectangles appear one per pulse while the flush is still busy. The redraw pulse comes in the cycle after acceptance, without any busy cycle. A monitor logs both at every falling edge, and the flush task compares the logged count and contents only after the engine is idle again. Write ordering is judged from the first write address logged after each copy command.

// File: rtl/rfe_pkg.sv
package rfe_pkg;

  localparam logic [1:0] OP_FILL  = 2'd0;
  localparam logic [1:0] OP_COPY  = 2'd1;
  localparam logic [1:0] OP_FLUSH = 2'd2;

  typedef enum logic [2:0] {
    MV_IDLE,
    MV_SETUP,
    MV_FILL,
    MV_RD,
    MV_WAIT,
    MV_WR,
    MV_PUSH
  } mv_state_e;

  typedef enum logic [1:0] {
    DQ_IDLE,
    DQ_RD,
    DQ_OUT
  } dq_state_e;

endpackage

// File: rtl/rfe_clip.sv
// Clamps one axis of a rectangle against the screen limit.
module rfe_clip #(
  parameter int W = 12
) (
  input  logic [W-1:0] pos,
  input  logic [W-1:0] len,
  input  logic [W-1:0] lim,
  output logic [W-1:0] pos_o,
  output logic [W-1:0] len_o
);
  logic [W:0] span;

  always_comb begin
    span  = {1'b0, pos} + {1'b0, len};
    pos_o = pos;
    len_o = len;
    if (span > {1'b0, lim}) begin
      pos_o = (pos < lim) ? pos : lim;
      len_o = lim - pos_o;
    end
  end
endmodule

// File: rtl/rfe_mover.sv
// Byte walker for solid fills and overlap-safe copies.
module rfe_mover
  import rfe_pkg::*;
#(
  parameter int COORD_W = 12,
  parameter int ADDR_W  = 24
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               is_copy,
  input  logic [31:0]        color,
  input  logic [COORD_W-1:0] src_x,
  input  logic [COORD_W-1:0] src_y,
  input  logic [COORD_W-1:0] dst_x,
  input  logic [COORD_W-1:0] dst_y,
  input  logic [COORD_W-1:0] rect_w,
  input  logic [COORD_W-1:0] rect_h,
  input  logic [2:0]         bpp,
  input  logic [COORD_W-1:0] scr_w,
  output logic               busy,
  output logic               push,
  output logic [4*COORD_W-1:0] push_rect,
  output logic               mem_rd_en,
  output logic [ADDR_W-1:0]  mem_rd_addr,
  input  logic [7:0]         mem_rd_data,
  output logic               mem_wr_en,
  output logic [ADDR_W-1:0]  mem_wr_addr,
  output logic [7:0]         mem_wr_data
);
  localparam int BW = COORD_W + 3;

  mv_state_e          st;
  logic               c_copy;
  logic [31:0]        c_color;
  logic [COORD_W-1:0] c_sx, c_sy, c_dx, c_dy, c_w, c_h;
  logic [BW-1:0]      nb, k;
  logic [1:0]         ph;
  logic [COORD_W-1:0] r;
  logic [ADDR_W-1:0]  s_row, d_row;
  logic               rev_r, rev_c;

  logic [ADDR_W-1:0]  pitch;
  logic               rev_r_n;
  logic [COORD_W-1:0] yoff;
  logic [BW-1:0]      byte_off;
  logic               last_byte, last_row, ph_wrap, adv;
  logic [31:0]        col_sh;

  always_comb begin
    pitch     = ADDR_W'(bpp) * ADDR_W'(scr_w);
    rev_r_n   = c_copy && (c_dy > c_sy);
    yoff      = rev_r_n ? (c_h - COORD_W'(1)) : '0;
    byte_off  = rev_c ? (nb - BW'(1) - k) : k;
    last_byte = (k == nb - BW'(1));
    last_row  = (r == c_h - COORD_W'(1));
    ph_wrap   = ({1'b0, ph} == (bpp - 3'd1));
    col_sh    = c_color >> {ph, 3'b000};
    adv       = (st == MV_FILL) || (st == MV_WR);
  end

  assign busy      = (st != MV_IDLE);
  assign push      = (st == MV_PUSH);
  assign push_rect = {c_h, c_w, c_dy, c_dx};

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= MV_IDLE;
      c_copy      <= 1'b0;
      c_color     <= '0;
      c_sx        <= '0;
      c_sy        <= '0;
      c_dx        <= '0;
      c_dy        <= '0;
      c_w         <= '0;
      c_h         <= '0;
      nb          <= '0;
      k           <= '0;
      ph          <= '0;
      r           <= '0;
      s_row       <= '0;
      d_row       <= '0;
      rev_r       <= 1'b0;
      rev_c       <= 1'b0;
      mem_rd_en   <= 1'b0;
      mem_rd_addr <= '0;
      mem_wr_en   <= 1'b0;
      mem_wr_addr <= '0;
      mem_wr_data <= '0;
    end else begin
      mem_rd_en <= 1'b0;
      mem_wr_en <= 1'b0;
      case (st)
        MV_IDLE: begin
          if (start) begin
            c_copy  <= is_copy;
            c_color <= color;
            c_sx    <= src_x;
            c_sy    <= src_y;
            c_dx    <= dst_x;
            c_dy    <= dst_y;
            c_w     <= rect_w;
            c_h     <= rect_h;
            st      <= MV_SETUP;
          end
        end
        MV_SETUP: begin
          rev_r <= rev_r_n;
          rev_c <= c_copy && (c_dx > c_sx);
          nb    <= BW'(bpp) * BW'(c_w);
          k     <= '0;
          ph    <= '0;
          r     <= '0;
          s_row <= ADDR_W'(bpp) * ADDR_W'(c_sx) + pitch * ADDR_W'(c_sy + yoff);
          d_row <= ADDR_W'(bpp) * ADDR_W'(c_dx) + pitch * ADDR_W'(c_dy + yoff);
          if (c_w == '0 || c_h == '0) st <= MV_PUSH;
          else                        st <= c_copy ? MV_RD : MV_FILL;
        end
        MV_FILL: begin
          mem_wr_en   <= 1'b1;
          mem_wr_addr <= d_row + ADDR_W'(byte_off);
          mem_wr_data <= col_sh[7:0];
        end
        MV_RD: begin
          mem_rd_en   <= 1'b1;
          mem_rd_addr <= s_row + ADDR_W'(byte_off);
          st          <= MV_WAIT;
        end
        MV_WAIT: st <= MV_WR;
        MV_WR: begin
          mem_wr_en   <= 1'b1;
          mem_wr_addr <= d_row + ADDR_W'(byte_off);
          mem_wr_data <= mem_rd_data;
        end
        MV_PUSH: st <= MV_IDLE;
        default: st <= MV_IDLE;
      endcase

      if (adv) begin
        if (last_byte) begin
          k     <= '0;
          ph    <= '0;
          r     <= r + COORD_W'(1);
          s_row <= rev_r ? (s_row - pitch) : (s_row + pitch);
          d_row <= rev_r ? (d_row - pitch) : (d_row + pitch);
          st    <= last_row ? MV_PUSH : (c_copy ? MV_RD : MV_FILL);
        end else begin
          k  <= k + BW'(1);
          ph <= ph_wrap ? 2'd0 : (ph + 2'd1);
          st <= c_copy ? MV_RD : MV_FILL;
        end
      end
    end
  end
endmodule

// File: rtl/rfe_dirty_queue.sv
// Circular damage queue with flush-time clipping.
module rfe_dirty_queue
  import rfe_pkg::*;
#(
  parameter int COORD_W = 12,
  parameter int DEPTH   = 512
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 push,
  input  logic [4*COORD_W-1:0] push_rect,
  input  logic                 flush_start,
  input  logic                 redraw_pend,
  input  logic [COORD_W-1:0]   scr_w,
  input  logic [COORD_W-1:0]   scr_h,
  output logic                 busy,
  output logic                 dmg_valid,
  output logic [COORD_W-1:0]   dmg_x,
  output logic [COORD_W-1:0]   dmg_y,
  output logic [COORD_W-1:0]   dmg_w,
  output logic [COORD_W-1:0]   dmg_h,
  output logic                 redraw_all
);
  localparam int PW = $clog2(DEPTH);
  localparam int EW = 4 * COORD_W;

  logic [EW-1:0] ram [DEPTH];
  logic [EW-1:0] ram_q;
  logic [PW-1:0] wr_ptr, rd_ptr;
  dq_state_e     st;
  logic          ram_re;

  logic [COORD_W-1:0] ax_pos [2];
  logic [COORD_W-1:0] ax_len [2];
  logic [COORD_W-1:0] ax_lim [2];
  logic [COORD_W-1:0] ax_po  [2];
  logic [COORD_W-1:0] ax_lo  [2];

  assign ram_re = (st == DQ_RD) && (rd_ptr != wr_ptr);
  assign busy   = (st != DQ_IDLE);

  always_ff @(posedge clk) begin
    if (push) ram[wr_ptr] <= push_rect;
    if (ram_re) ram_q <= ram[rd_ptr];
  end

  // entry layout {h, w, y, x}; axis 0 is horizontal, axis 1 vertical
  assign ax_pos[0] = ram_q[COORD_W-1:0];
  assign ax_pos[1] = ram_q[2*COORD_W-1:COORD_W];
  assign ax_len[0] = ram_q[3*COORD_W-1:2*COORD_W];
  assign ax_len[1] = ram_q[4*COORD_W-1:3*COORD_W];
  assign ax_lim[0] = scr_w;
  assign ax_lim[1] = scr_h;

  for (genvar a = 0; a < 2; a++) begin : g_axis
    rfe_clip #(.W(COORD_W)) u_clip (
      .pos  (ax_pos[a]),
      .len  (ax_len[a]),
      .lim  (ax_lim[a]),
      .pos_o(ax_po[a]),
      .len_o(ax_lo[a])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= DQ_IDLE;
      wr_ptr     <= '0;
      rd_ptr     <= '0;
      dmg_valid  <= 1'b0;
      redraw_all <= 1'b0;
      dmg_x      <= '0;
      dmg_y      <= '0;
      dmg_w      <= '0;
      dmg_h      <= '0;
    end else begin
      dmg_valid  <= 1'b0;
      redraw_all <= 1'b0;
      if (push) wr_ptr <= wr_ptr + PW'(1);
      case (st)
        DQ_IDLE: begin
          if (flush_start) begin
            if (redraw_pend) begin
              rd_ptr     <= wr_ptr;
              redraw_all <= 1'b1;
            end else begin
              st <= DQ_RD;
            end
          end
        end
        DQ_RD: begin
          if (rd_ptr == wr_ptr) begin
            st <= DQ_IDLE;
          end else begin
            rd_ptr <= rd_ptr + PW'(1);
            st     <= DQ_OUT;
          end
        end
        DQ_OUT: begin
          dmg_valid <= 1'b1;
          dmg_x     <= ax_po[0];
          dmg_w     <= ax_lo[0];
          dmg_y     <= ax_po[1];
          dmg_h     <= ax_lo[1];
          st        <= DQ_RD;
        end
        default: st <= DQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rect_blit_engine.sv
module rect_blit_engine
  import rfe_pkg::*;
#(
  parameter int COORD_W  = 12,
  parameter int ADDR_W   = 24,
  parameter int DQ_DEPTH = 512
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [2:0]         cfg_bpp,
  input  logic [COORD_W-1:0] cfg_scr_w,
  input  logic [COORD_W-1:0] cfg_scr_h,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [1:0]         cmd_op,
  input  logic [31:0]        cmd_color,
  input  logic [COORD_W-1:0] cmd_src_x,
  input  logic [COORD_W-1:0] cmd_src_y,
  input  logic [COORD_W-1:0] cmd_dst_x,
  input  logic [COORD_W-1:0] cmd_dst_y,
  input  logic [COORD_W-1:0] cmd_w,
  input  logic [COORD_W-1:0] cmd_h,
  input  logic               redraw_pend,
  output logic               busy,
  output logic               mem_rd_en,
  output logic [ADDR_W-1:0]  mem_rd_addr,
  input  logic [7:0]         mem_rd_data,
  output logic               mem_wr_en,
  output logic [ADDR_W-1:0]  mem_wr_addr,
  output logic [7:0]         mem_wr_data,
  output logic               dmg_valid,
  output logic [COORD_W-1:0] dmg_x,
  output logic [COORD_W-1:0] dmg_y,
  output logic [COORD_W-1:0] dmg_w,
  output logic [COORD_W-1:0] dmg_h,
  output logic               redraw_all
);
  logic                 take, mv_start, fl_start;
  logic                 mv_busy, dq_busy;
  logic                 push;
  logic [4*COORD_W-1:0] push_rect;

  assign busy      = mv_busy | dq_busy;
  assign cmd_ready = ~busy;
  assign take      = cmd_valid & cmd_ready;
  assign mv_start  = take & ((cmd_op == OP_FILL) | (cmd_op == OP_COPY));
  assign fl_start  = take & (cmd_op == OP_FLUSH);

  rfe_mover #(.COORD_W(COORD_W), .ADDR_W(ADDR_W)) u_mover (
    .clk        (clk),
    .rst        (rst),
    .start      (mv_start),
    .is_copy    (cmd_op == OP_COPY),
    .color      (cmd_color),
    .src_x      (cmd_src_x),
    .src_y      (cmd_src_y),
    .dst_x      (cmd_dst_x),
    .dst_y      (cmd_dst_y),
    .rect_w     (cmd_w),
    .rect_h     (cmd_h),
    .bpp        (cfg_bpp),
    .scr_w      (cfg_scr_w),
    .busy       (mv_busy),
    .push       (push),
    .push_rect  (push_rect),
    .mem_rd_en  (mem_rd_en),
    .mem_rd_addr(mem_rd_addr),
    .mem_rd_data(mem_rd_data),
    .mem_wr_en  (mem_wr_en),
    .mem_wr_addr(mem_wr_addr),
    .mem_wr_data(mem_wr_data)
  );

  rfe_dirty_queue #(.COORD_W(COORD_W), .DEPTH(DQ_DEPTH)) u_queue (
    .clk        (clk),
    .rst        (rst),
    .push       (push),
    .push_rect  (push_rect),
    .flush_start(fl_start),
    .redraw_pend(redraw_pend),
    .scr_w      (cfg_scr_w),
    .scr_h      (cfg_scr_h),
    .busy       (dq_busy),
    .dmg_valid  (dmg_valid),
    .dmg_x      (dmg_x),
    .dmg_y      (dmg_y),
    .dmg_w      (dmg_w),
    .dmg_h      (dmg_h),
    .redraw_all (redraw_all)
  );
endmodule

// File: rtl/rect_blit_engine_chk.sv
module rect_blit_engine_chk #(
  parameter int COORD_W = 12
) (
  input logic               clk,
  input logic               rst,
  input logic               cmd_valid,
  input logic               cmd_ready,
  input logic [1:0]         cmd_op,
  input logic               busy,
  input logic               mem_rd_en,
  input logic               mem_wr_en,
  input logic               dmg_valid,
  input logic [COORD_W-1:0] dmg_x,
  input logic [COORD_W-1:0] dmg_y,
  input logic [COORD_W-1:0] dmg_w,
  input logic [COORD_W-1:0] dmg_h,
  input logic [COORD_W-1:0] cfg_scr_w,
  input logic [COORD_W-1:0] cfg_scr_h,
  input logic               redraw_all
);
  p_take_busy_r10: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready && (cmd_op == 2'd0 || cmd_op == 2'd1)) |=> busy);

  p_nop_idle_r10: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready && cmd_op == 2'd3) |=> !busy);

  p_rw_excl_r3: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd_en && mem_wr_en));

  p_quiet_idle_r11: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mem_rd_en && !mem_wr_en && !dmg_valid));

  p_clip_x_r9: assert property (@(posedge clk) disable iff (rst)
    dmg_valid |-> ({1'b0, dmg_x} + {1'b0, dmg_w} <= {1'b0, cfg_scr_w}));

  p_clip_y_r9: assert property (@(posedge clk) disable iff (rst)
    dmg_valid |-> ({1'b0, dmg_y} + {1'b0, dmg_h} <= {1'b0, cfg_scr_h}));

  p_redraw_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    redraw_all |=> !redraw_all);

  p_redraw_no_dmg_r8: assert property (@(posedge clk) disable iff (rst)
    redraw_all |-> !dmg_valid);
endmodule

bind rect_blit_engine rect_blit_engine_chk #(.COORD_W(COORD_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_op    (cmd_op),
  .busy      (busy),
  .mem_rd_en (mem_rd_en),
  .mem_wr_en (mem_wr_en),
  .dmg_valid (dmg_valid),
  .dmg_x     (dmg_x),
  .dmg_y     (dmg_y),
  .dmg_w     (dmg_w),
  .dmg_h     (dmg_h),
  .cfg_scr_w (cfg_scr_w),
  .cfg_scr_h (cfg_scr_h),
  .redraw_all(redraw_all)
);

// File: tb/rect_blit_engine_tb_top.sv
module rect_blit_engine_tb_top;
  localparam int CW = 12;
  localparam int AW = 16;
  localparam int MS = 4096;
  localparam int SW = 16;
  localparam int SH = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst;
  logic [2:0]    cfg_bpp;
  logic [CW-1:0] cfg_scr_w, cfg_scr_h;
  logic          cmd_valid, cmd_ready, redraw_pend, busy;
  logic [1:0]    cmd_op;
  logic [31:0]   cmd_color;
  logic [CW-1:0] cmd_src_x, cmd_src_y, cmd_dst_x, cmd_dst_y, cmd_w, cmd_h;
  logic          mem_rd_en, mem_wr_en, mem_init;
  logic [AW-1:0] mem_rd_addr, mem_wr_addr;
  logic [7:0]    mem_rd_data, mem_wr_data;
  logic          dmg_valid, redraw_all;
  logic [CW-1:0] dmg_x, dmg_y, dmg_w, dmg_h;

  rect_blit_engine #(.COORD_W(CW), .ADDR_W(AW), .DQ_DEPTH(512)) dut_i (
    .clk(clk), .rst(rst), .cfg_bpp(cfg_bpp), .cfg_scr_w(cfg_scr_w), .cfg_scr_h(cfg_scr_h),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_color(cmd_color),
    .cmd_src_x(cmd_src_x), .cmd_src_y(cmd_src_y), .cmd_dst_x(cmd_dst_x), .cmd_dst_y(cmd_dst_y),
    .cmd_w(cmd_w), .cmd_h(cmd_h), .redraw_pend(redraw_pend), .busy(busy),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .dmg_valid(dmg_valid), .dmg_x(dmg_x), .dmg_y(dmg_y), .dmg_w(dmg_w), .dmg_h(dmg_h),
    .redraw_all(redraw_all)
  );

  // framebuffer model: one-cycle read latency, read-before-write
  logic [7:0] fb [MS];
  logic [7:0] rm [MS];
  logic [7:0] tmp [MS];
  always @(posedge clk) begin
    if (mem_init) for (int i = 0; i < MS; i++) fb[i] <= 8'(i * 7 + 3);
    if (mem_rd_en) mem_rd_data <= fb[mem_rd_addr[11:0]];
    if (mem_wr_en) fb[mem_wr_addr[11:0]] <= mem_wr_data;
  end

  // monitor, cumulative logs
  int gcount = 0, rcount = 0, wcount = 0;
  int gx [1024], gy [1024], gw [1024], gh [1024];
  int wlog [8192];
  always @(negedge clk) begin
    if (dmg_valid) begin
      gx[gcount % 1024] = dmg_x; gy[gcount % 1024] = dmg_y;
      gw[gcount % 1024] = dmg_w; gh[gcount % 1024] = dmg_h;
      gcount++;
    end
    if (redraw_all) rcount++;
    if (mem_wr_en) begin
      wlog[wcount % 8192] = mem_wr_addr;
      wcount++;
    end
  end

  int checks = 0, errors = 0;
  int ex [600], ey [600], ew [600], eh [600];
  int ecount = 0;
  bit track = 1;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_cmd(input logic [1:0] op, input logic [31:0] col,
                         input int sx, input int sy, input int x, input int y,
                         input int w, input int h);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_color = col;
    cmd_src_x = CW'(sx); cmd_src_y = CW'(sy); cmd_dst_x = CW'(x); cmd_dst_y = CW'(y);
    cmd_w = CW'(w); cmd_h = CW'(h);
    @(negedge clk);
    cmd_valid = 1'b0;
    while (busy) @(negedge clk);
    @(negedge clk);
    if (track && (op == 2'd0 || op == 2'd1)) begin
      ex[ecount] = x; ey[ecount] = y; ew[ecount] = w; eh[ecount] = h;
      ecount++;
    end
  endtask

  function automatic int paddr(int bpp, int x, int y);
    return bpp * x + bpp * SW * y;
  endfunction

  task automatic ref_fill(input int bpp, input logic [31:0] col, input int x, input int y,
                          input int w, input int h);
    for (int r = 0; r < h; r++)
      for (int b = 0; b < bpp * w; b++)
        rm[(paddr(bpp, x, y + r) + b) % MS] = 8'(col >> (8 * (b % bpp)));
  endtask

  task automatic ref_copy(input int bpp, input int sx, input int sy, input int x, input int y,
                          input int w, input int h);
    for (int i = 0; i < MS; i++) tmp[i] = rm[i];
    for (int r = 0; r < h; r++)
      for (int b = 0; b < bpp * w; b++)
        rm[(paddr(bpp, x, y + r) + b) % MS] = tmp[(paddr(bpp, sx, sy + r) + b) % MS];
  endtask

  task automatic cmp_mem(input string tag);
    int bad = 0, fa = 0, fe = 0;
    for (int i = 0; i < MS; i++)
      if (fb[i] !== rm[i]) begin
        if (bad == 0) begin fa = fb[i]; fe = rm[i]; end
        bad++;
      end
    chk(bad == 0, tag, fa, fe);
  endtask

  function automatic void clipv(input int p, input int l, input int lim, output int po, output int lo);
    po = p; lo = l;
    if (p + l > lim) begin
      po = (p < lim) ? p : lim;
      lo = lim - po;
    end
  endfunction

  task automatic do_flush(input bit redraw, input string tag);
    int g0, r0, bad, px, pw, py, ph;
    g0 = gcount; r0 = rcount; bad = 0;
    redraw_pend = redraw;
    run_cmd(2'd2, 0, 0, 0, 0, 0, 0, 0);
    redraw_pend = 1'b0;
    if (redraw) begin
      chk(rcount - r0 == 1, tag, rcount - r0, 1);
      chk(gcount - g0 == 0, tag, gcount - g0, 0);
    end else begin
      chk(gcount - g0 == ecount, tag, gcount - g0, ecount);
      for (int i = 0; i < ecount && i < gcount - g0; i++) begin
        clipv(ex[i], ew[i], int'(cfg_scr_w), px, pw);
        clipv(ey[i], eh[i], int'(cfg_scr_h), py, ph);
        if (gx[(g0 + i) % 1024] != px || gw[(g0 + i) % 1024] != pw ||
            gy[(g0 + i) % 1024] != py || gh[(g0 + i) % 1024] != ph) bad++;
      end
      chk(bad == 0, tag, bad, 0);
    end
    ecount = 0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int w0, a;
    rst = 1'b1; mem_init = 1'b1; cmd_valid = 1'b0; cmd_op = 2'd0; cmd_color = '0;
    cmd_src_x = '0; cmd_src_y = '0; cmd_dst_x = '0; cmd_dst_y = '0; cmd_w = '0; cmd_h = '0;
    redraw_pend = 1'b0; cfg_bpp = 3'd1; cfg_scr_w = CW'(SW); cfg_scr_h = CW'(SH);
    for (int i = 0; i < MS; i++) rm[i] = 8'(i * 7 + 3);
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0; mem_init = 1'b0;
    @(negedge clk);
    // R11: reset state
    chk(!busy && cmd_ready, "R11 idle/ready", {busy, cmd_ready}, 1);
    chk(!mem_rd_en && !mem_wr_en && !dmg_valid && !redraw_all, "R11 outputs quiet",
        {mem_rd_en, mem_wr_en, dmg_valid, redraw_all}, 0);

    // R1/R2: fill sweep over pixel sizes and rectangles
    for (int bpp = 1; bpp <= 4; bpp++) begin
      cfg_bpp = 3'(bpp);
      for (int t = 0; t < 3; t++) begin
        w0 = wcount;
        run_cmd(2'd0, 32'hA1B2C3D4 + 32'(t * 32'h01010101), 0, 0, t * 3 + 1, t + 1, 5 - t, 2 + t);
        ref_fill(bpp, 32'hA1B2C3D4 + 32'(t * 32'h01010101), t * 3 + 1, t + 1, 5 - t, 2 + t);
        chk(wcount - w0 == bpp * (5 - t) * (2 + t), "R1 write count", wcount - w0, bpp * (5 - t) * (2 + t));
        cmp_mem("R1 R2 fill contents");
      end
    end
    do_flush(1'b0, "R6 order after fills");

    // R3: destination below source, overlapping
    cfg_bpp = 3'd2;
    w0 = wcount;
    run_cmd(2'd1, 0, 2, 1, 3, 3, 5, 4);
    ref_copy(2, 2, 1, 3, 3, 5, 4);
    a = paddr(2, 3, 6) + 9;
    chk(wlog[w0 % 8192] == a, "R3 first write bottom row", wlog[w0 % 8192], a);
    cmp_mem("R3 copy contents");
    // R4: destination above source
    w0 = wcount;
    run_cmd(2'd1, 0, 5, 4, 3, 2, 4, 3);
    ref_copy(2, 5, 4, 3, 2, 4, 3);
    a = paddr(2, 3, 2);
    chk(wlog[w0 % 8192] == a, "R4 first write top row", wlog[w0 % 8192], a);
    cmp_mem("R4 copy contents");
    // R5: same row, shifted right
    w0 = wcount;
    run_cmd(2'd1, 0, 2, 2, 4, 2, 6, 1);
    ref_copy(2, 2, 2, 4, 2, 6, 1);
    a = paddr(2, 4, 2) + 11;
    chk(wlog[w0 % 8192] == a, "R5 first write right end", wlog[w0 % 8192], a);
    cmp_mem("R5 copy right");
    run_cmd(2'd1, 0, 5, 5, 3, 5, 6, 2);
    ref_copy(2, 5, 5, 3, 5, 6, 2);
    cmp_mem("R5 copy left");
    do_flush(1'b0, "R6 order after copies");

    // R3 R4 R5: sweep of overlapping offsets, bpp 3
    cfg_bpp = 3'd3;
    for (int ddy = -2; ddy <= 2; ddy++) begin
      for (int ddx = -2; ddx <= 2; ddx++) begin
        run_cmd(2'd1, 0, 6, 3, 6 + ddx, 3 + ddy, 4, 3);
        ref_copy(3, 6, 3, 6 + ddx, 3 + ddy, 4, 3);
      end
      cmp_mem(ddy > 0 ? "R3 sweep" : "R4 R5 sweep");
      do_flush(1'b0, "R6 sweep damage");
    end

    // R12: zero-size fill and copy
    w0 = wcount;
    run_cmd(2'd0, 32'hFF, 0, 0, 2, 2, 0, 3);
    run_cmd(2'd1, 0, 1, 1, 4, 4, 3, 0);
    chk(wcount - w0 == 0, "R12 no writes", wcount - w0, 0);
    do_flush(1'b0, "R12 pushed");

    // R10: no-operation code
    w0 = wcount;
    track = 1'b0;
    run_cmd(2'd3, 32'h55, 1, 1, 2, 2, 3, 3);
    track = 1'b1;
    chk(wcount - w0 == 0 && !busy, "R10 nop no effect", wcount - w0, 0);
    do_flush(1'b0, "R10 nop no damage");

    // R9: clipping against a smaller screen at flush
    cfg_bpp = 3'd1;
    run_cmd(2'd0, 32'h11, 0, 0, 10, 1, 6, 2);
    run_cmd(2'd0, 32'h22, 0, 0, 14, 3, 2, 5);
    run_cmd(2'd0, 32'h33, 0, 0, 2, 5, 3, 3);
    ref_fill(1, 32'h11, 10, 1, 6, 2);
    ref_fill(1, 32'h22, 14, 3, 2, 5);
    ref_fill(1, 32'h33, 2, 5, 3, 3);
    cmp_mem("R1 fill before clip");
    cfg_scr_w = CW'(12); cfg_scr_h = CW'(6);
    do_flush(1'b0, "R9 clipped damage");
    cfg_scr_w = CW'(SW); cfg_scr_h = CW'(SH);

    // R8: redraw pending drops the queue
    run_cmd(2'd0, 32'h44, 0, 0, 1, 1, 1, 1);
    run_cmd(2'd0, 32'h45, 0, 0, 2, 2, 1, 1);
    ref_fill(1, 32'h44, 1, 1, 1, 1);
    ref_fill(1, 32'h45, 2, 2, 1, 1);
    do_flush(1'b1, "R8 redraw pulse");
    do_flush(1'b0, "R8 queue empty after redraw");

    // R7: 512 pushes lap the queue
    track = 1'b0;
    for (int i = 0; i < 512; i++) run_cmd(2'd0, 0, 0, 0, i % 16, 1, 0, 1);
    track = 1'b1;
    do_flush(1'b0, "R7 lapped queue empty");
    run_cmd(2'd0, 0, 0, 0, 5, 4, 0, 2);
    do_flush(1'b0, "R7 single entry after lap");
    cmp_mem("R7 memory untouched");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule